// File: doc/BRIEF.md
# Video write FIFO slot scheduler

This block keeps the write queue of a video display controller as a count of access slots rather than as stored data. A CPU data-port write or a DMA request hands it one transfer entry: a number of writes plus two flags, one marking a byte-wide access and one marking a DMA fill. The entries wait in an eight-place ring. Each strobe on the slot-tick input spends one access slot on the oldest entry. A word write costs one slot and a byte-wide write costs two.

The block reports how many writes are still pending and how many entries are queued. It also reports a coarse level: empty, in use or full. It holds the CPU while a CPU write has left the queue at or above the full level, and while a CPU read waits for its access slot. When a CPU write arrives while the oldest entry is a DMA fill, the fill is cut short at once and the fill-active flag drops. Converting bus cycles to slots, address generation and moving the data itself are left to the surrounding logic.

Top module: `vfifo_slot_sched`

## Requirements
- R1: After reset, pending_total and queue_len are 0, fifo_state is 0, and cpu_stall, fill_active and rd_grant are all low.
- R2: A request with enq_valid high, a nonzero enq_count and fewer than 8 queued entries adds one entry. The cycle after it, queue_len is one higher and pending_total is higher by enq_count. A request with enq_count of 0 changes neither value.
- R3: When 8 entries are already queued, a further request is dropped, and queue_len and pending_total are unchanged the cycle after it.
- R4: For a word entry (enq_byte low), each slot_tick while queue_len is nonzero retires one write, so pending_total is one lower the cycle after the tick.
- R5: For a byte entry (enq_byte high), each write costs two slot ticks. pending_total stays put after the first tick of a write and drops by one after the second.
- R6: Entries drain oldest first. queue_len drops by one after the tick that spends the last slot of the oldest entry. A slot_tick while queue_len is 0 changes nothing.
- R7: fifo_state is 0 (empty) when pending_total is 0, 1 (in use) when pending_total is 1 to 3, and 2 (full) when pending_total is 4 or more.
- R8: After a CPU write (enq_cpu high) that leaves pending_total at 4 or more, cpu_stall stays high until the cycle in which pending_total falls below 4. A DMA request (enq_cpu low) that reaches the same level does not raise cpu_stall.
- R9: A CPU write that arrives while the oldest entry is a DMA fill retires every remaining slot of that fill in the same cycle. For a byte fill with half a write already spent, that half write counts as a whole one. The cycle after, pending_total has lost the fill's remaining writes and gained the CPU write's count, and fill_active is low.
- R10: fill_active goes high the cycle after a DMA fill request (enq_fill high, enq_cpu low) is accepted, and goes low after that fill entry has drained through slot ticks.
- R11: After rd_req, cpu_stall is high from the next cycle. On the first slot_tick in a later cycle than the request, rd_grant pulses high for one cycle and cpu_stall drops in that same cycle.
- R12: When a request and a slot_tick arrive in the same cycle, the tick is spent on the entries already queued. If the queue was empty, the new entry keeps its whole budget.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Transfer request strobe |
| enq_count | input | CNT_W | Number of writes in the request |
| enq_byte | input | 1 | Request uses byte-wide accesses (two slots per write) |
| enq_fill | input | 1 | Request is a DMA fill (ignored on CPU writes) |
| enq_cpu | input | 1 | Request is a CPU data-port write |
| slot_tick | input | 1 | One external access slot is available |
| rd_req | input | 1 | CPU read request strobe |
| fifo_state | output | 2 | 0 empty, 1 in use, 2 full |
| pending_total | output | TOT_W | Writes still pending |
| queue_len | output | LEN_W | Entries queued |
| cpu_stall | output | 1 | CPU must wait |
| fill_active | output | 1 | A DMA fill is in progress |
| rd_grant | output | 1 | One-cycle pulse: CPU read served |

## Verification
The hardest case to reach is a CPU write that cuts into a byte-wide DMA fill after an odd number of its slots have been spent. Only then does the half-finished write have to round up when the fill is retired. The stimulus queues a byte fill, spends exactly one slot tick on it, and then issues a CPU write. It checks that pending_total lands on the CPU write's count alone and that fill_active has dropped. A similar hand-timed case puts a request and a tick in the same cycle, once on an empty queue and once behind an existing entry, to show which entry the tick is charged to.

// File: rtl/vfifo_pkg.sv
package vfifo_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_INUSE = 2'd1,
        FS_FULL  = 2'd2
    } fifo_level_e;

    typedef struct packed {
        logic fill;
        logic byte_acc;
    } xfer_flags_t;

endpackage

// File: rtl/vfifo_level.sv
module vfifo_level
    import vfifo_pkg::*;
#(
    parameter int unsigned TOT_W    = 11,
    parameter int unsigned FULL_LVL = 4
) (
    input  logic [TOT_W-1:0] total,
    output fifo_level_e      level
);

    localparam logic [TOT_W-1:0] FULL_T = TOT_W'(FULL_LVL);

    always_comb begin
        if (total == '0)
            level = FS_EMPTY;
        else if (total >= FULL_T)
            level = FS_FULL;
        else
            level = FS_INUSE;
    end

endmodule

// File: rtl/vfifo_cpu_hold.sv
module vfifo_cpu_hold #(
    parameter int unsigned TOT_W    = 11,
    parameter int unsigned FULL_LVL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [TOT_W-1:0] total_next,
    input  logic             rd_req,
    input  logic             slot_tick,
    output logic             cpu_stall,
    output logic             rd_grant
);

    localparam logic [TOT_W-1:0] FULL_T = TOT_W'(FULL_LVL);

    typedef struct packed {
        logic wr_wait;
        logic rd_wait;
        logic grant;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d         = hold_q;
        hold_d.grant   = hold_q.rd_wait & slot_tick;
        hold_d.rd_wait = (hold_q.rd_wait & ~slot_tick) | rd_req;
        hold_d.wr_wait = (hold_q.wr_wait | cpu_wr) & (total_next >= FULL_T);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else
            hold_q <= hold_d;
    end

    assign cpu_stall = hold_q.wr_wait | hold_q.rd_wait;
    assign rd_grant  = hold_q.grant;

    // R11
    rd_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> cpu_stall);

    // R11
    grant_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> $past(slot_tick));

    // R8
    wr_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && total_next >= FULL_T) |=> cpu_stall);

endmodule

// File: rtl/vfifo_slot_sched.sv
module vfifo_slot_sched
    import vfifo_pkg::*;
#(
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned FULL_LVL = 4,
    localparam int unsigned IDX_W   = $clog2(DEPTH),
    localparam int unsigned LEN_W   = $clog2(DEPTH + 1),
    localparam int unsigned TOT_W   = $clog2(DEPTH * (2 ** CNT_W) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [CNT_W-1:0] enq_count,
    input  logic             enq_byte,
    input  logic             enq_fill,
    input  logic             enq_cpu,
    input  logic             slot_tick,
    input  logic             rd_req,
    output logic [1:0]       fifo_state,
    output logic [TOT_W-1:0] pending_total,
    output logic [LEN_W-1:0] queue_len,
    output logic             cpu_stall,
    output logic             fill_active,
    output logic             rd_grant
);

    localparam int unsigned REM_W = CNT_W + 1;
    localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        xfer_flags_t      flags;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ring;
        logic [IDX_W-1:0]   head;
        logic [LEN_W-1:0]   len;
        logic [REM_W-1:0]   rem;
        logic [TOT_W-1:0]   total;
        logic               fill_act;
    } sched_t;

    // slots an entry costs: count, doubled for byte-wide access
    function automatic logic [REM_W-1:0] slot_budget(input entry_t e);
        return REM_W'(e.count) << e.flags.byte_acc;
    endfunction

    // writes retired when `used` slots are spent out of `rem` remaining
    function automatic logic [TOT_W-1:0] writes_done(
        input logic [REM_W-1:0] rem,
        input logic [REM_W-1:0] used,
        input logic             byte_acc
    );
        logic [REM_W:0] sum;
        sum = {1'b0, used} + {{REM_W{1'b0}}, (rem[0] & byte_acc)};
        if (byte_acc)
            sum = sum >> 1;
        return TOT_W'(sum);
    endfunction

    sched_t           st_d, st_q;
    entry_t           hd_e, new_e;
    logic [IDX_W-1:0] tail;
    logic             accept, kill_fill;

    always_comb begin
        st_d      = st_q;
        hd_e      = st_q.ring[st_q.head];
        new_e     = '0;
        tail      = '0;
        accept    = 1'b0;
        kill_fill = 1'b0;

        // step 1: one slot on the existing head
        if (slot_tick && st_d.len != '0) begin
            hd_e       = st_d.ring[st_d.head];
            st_d.total = st_d.total - writes_done(st_d.rem, REM_W'(1), hd_e.flags.byte_acc);
            st_d.rem   = st_d.rem - REM_W'(1);
            if (st_d.rem == '0) begin
                if (hd_e.flags.fill)
                    st_d.fill_act = 1'b0;
                st_d.head = st_d.head + IDX_W'(1);
                st_d.len  = st_d.len - LEN_W'(1);
                st_d.rem  = (st_d.len != '0) ? slot_budget(st_d.ring[st_d.head]) : '0;
            end
        end

        // step 2: append the new request
        accept = enq_valid && (enq_count != '0) && (st_d.len < DEPTH_L);
        if (accept) begin
            new_e.count          = enq_count;
            new_e.flags.byte_acc = enq_byte;
            new_e.flags.fill     = enq_fill & ~enq_cpu;
            if (st_d.total == '0)
                st_d.rem = slot_budget(new_e);
            tail            = st_d.head + st_d.len[IDX_W-1:0];
            st_d.ring[tail] = new_e;
            st_d.len        = st_d.len + LEN_W'(1);
            st_d.total      = st_d.total + TOT_W'(enq_count);
            if (new_e.flags.fill)
                st_d.fill_act = 1'b1;
        end

        // step 3: a CPU write cuts a running fill short
        kill_fill = enq_valid && enq_cpu && (st_d.len != '0)
                    && st_d.ring[st_d.head].flags.fill;
        if (kill_fill) begin
            hd_e          = st_d.ring[st_d.head];
            st_d.total    = st_d.total - writes_done(st_d.rem, st_d.rem, hd_e.flags.byte_acc);
            st_d.fill_act = 1'b0;
            st_d.head     = st_d.head + IDX_W'(1);
            st_d.len      = st_d.len - LEN_W'(1);
            st_d.rem      = (st_d.len != '0) ? slot_budget(st_d.ring[st_d.head]) : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    fifo_level_e level;

    vfifo_level #(
        .TOT_W    (TOT_W),
        .FULL_LVL (FULL_LVL)
    ) u_level (
        .total (st_q.total),
        .level (level)
    );

    vfifo_cpu_hold #(
        .TOT_W    (TOT_W),
        .FULL_LVL (FULL_LVL)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr     (enq_valid & enq_cpu),
        .total_next (st_d.total),
        .rd_req     (rd_req),
        .slot_tick  (slot_tick),
        .cpu_stall  (cpu_stall),
        .rd_grant   (rd_grant)
    );

    assign fifo_state    = level;
    assign pending_total = st_q.total;
    assign queue_len     = st_q.len;
    assign fill_active   = st_q.fill_act;

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enq_valid && !slot_tick) |=> ($stable(st_q.total) && $stable(st_q.len)));

    // R3
    ring_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && !enq_cpu && !slot_tick && st_q.len == DEPTH_L)
            |=> (st_q.len == DEPTH_L && $stable(st_q.total)));

    // R7
    empty_consistent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.total == '0) == (st_q.len == '0));

    // R9
    fill_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_cpu && st_q.len != '0 && st_q.ring[st_q.head].flags.fill)
            |=> !st_q.fill_act);

    // R2
    len_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (st_q.len <= $past(st_q.len) + LEN_W'(1)));

endmodule

// File: tb/tb_vfifo_slot_sched.sv
module tb_vfifo_slot_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enq_valid = 1'b0;
    logic [7:0]  enq_count = '0;
    logic        enq_byte = 1'b0;
    logic        enq_fill = 1'b0;
    logic        enq_cpu = 1'b0;
    logic        slot_tick = 1'b0;
    logic        rd_req = 1'b0;
    logic [1:0]  fifo_state;
    logic [10:0] pending_total;
    logic [3:0]  queue_len;
    logic        cpu_stall, fill_active, rd_grant;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vfifo_slot_sched dut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_count(enq_count),
        .enq_byte(enq_byte), .enq_fill(enq_fill), .enq_cpu(enq_cpu),
        .slot_tick(slot_tick), .rd_req(rd_req), .fifo_state(fifo_state),
        .pending_total(pending_total), .queue_len(queue_len), .cpu_stall(cpu_stall),
        .fill_active(fill_active), .rd_grant(rd_grant)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // one cycle of stimulus, then inputs return to idle
    task automatic cyc(input bit v, input int cnt, input bit b, input bit f,
                       input bit cpu, input bit tk, input bit rd);
        enq_valid = v; enq_count = 8'(cnt); enq_byte = b; enq_fill = f;
        enq_cpu = cpu; slot_tick = tk; rd_req = rd;
        step();
        enq_valid = 0; enq_count = '0; enq_byte = 0; enq_fill = 0;
        enq_cpu = 0; slot_tick = 0; rd_req = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic t_reset();
        chk("R1 total", pending_total, 0);
        chk("R1 len", queue_len, 0);
        chk("R1 state", fifo_state, 0);
        chk("R1 stall", cpu_stall, 0);
        chk("R1 fill", fill_active, 0);
        chk("R1 grant", rd_grant, 0);
    endtask

    task automatic t_word();
        cyc(1, 0, 0, 0, 0, 0, 0);
        chk("R2 zero count len", queue_len, 0);
        chk("R2 zero count total", pending_total, 0);
        cyc(1, 3, 0, 0, 0, 0, 0);
        chk("R2 len", queue_len, 1);
        chk("R2 total", pending_total, 3);
        chk("R7 in use", fifo_state, 1);
        ticks(1);
        chk("R4 total after tick", pending_total, 2);
        ticks(2);
        chk("R4 total drained", pending_total, 0);
        chk("R6 len drained", queue_len, 0);
        chk("R7 empty", fifo_state, 0);
        ticks(1);
        chk("R6 tick on empty", pending_total, 0);
        chk("R6 tick on empty len", queue_len, 0);
    endtask

    task automatic t_byte();
        cyc(1, 2, 1, 0, 0, 0, 0);
        chk("R5 total", pending_total, 2);
        ticks(1);
        chk("R5 first half", pending_total, 2);
        ticks(1);
        chk("R5 second half", pending_total, 1);
        ticks(1);
        chk("R5 third slot", pending_total, 1);
        ticks(1);
        chk("R5 done", pending_total, 0);
        chk("R5 len", queue_len, 0);
    endtask

    task automatic t_order();
        cyc(1, 1, 0, 0, 0, 0, 0);
        cyc(1, 1, 1, 0, 0, 0, 0);
        cyc(1, 2, 0, 0, 0, 0, 0);
        chk("R7 full", fifo_state, 2);
        chk("R8 DMA no stall", cpu_stall, 0);
        chk("R6 len 3", queue_len, 3);
        ticks(1);
        chk("R6 first out total", pending_total, 3);
        chk("R6 first out len", queue_len, 2);
        ticks(1);
        chk("R6 byte half total", pending_total, 3);
        chk("R6 byte half len", queue_len, 2);
        ticks(1);
        chk("R6 byte out total", pending_total, 2);
        chk("R6 byte out len", queue_len, 1);
        ticks(2);
        chk("R6 all out", pending_total, 0);
    endtask

    task automatic t_drop();
        for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, 0, 0, 0);
        chk("R3 len 8", queue_len, 8);
        chk("R3 total 8", pending_total, 8);
        cyc(1, 5, 0, 0, 0, 0, 0);
        chk("R3 dropped len", queue_len, 8);
        chk("R3 dropped total", pending_total, 8);
        ticks(8);
        chk("R3 drained", pending_total, 0);
    endtask

    task automatic t_stall();
        cyc(1, 5, 0, 0, 1, 0, 0);
        chk("R8 stall at 5", cpu_stall, 1);
        ticks(1);
        chk("R8 stall at 4", cpu_stall, 1);
        ticks(1);
        chk("R8 release at 3", cpu_stall, 0);
        chk("R8 total 3", pending_total, 3);
        ticks(3);
        cyc(1, 5, 0, 0, 0, 0, 0);
        chk("R8 DMA at 5 no stall", cpu_stall, 0);
        ticks(5);
    endtask

    task automatic t_fill();
        cyc(1, 6, 0, 1, 0, 0, 0);
        chk("R10 fill set", fill_active, 1);
        ticks(1);
        chk("R10 fill total", pending_total, 5);
        cyc(1, 2, 0, 0, 1, 0, 0);
        chk("R9 total after cut", pending_total, 2);
        chk("R9 len after cut", queue_len, 1);
        chk("R9 fill cleared", fill_active, 0);
        chk("R9 no stall", cpu_stall, 0);
        ticks(2);
        chk("R9 drained", pending_total, 0);
        // byte fill, half a write spent, then cut
        cyc(1, 3, 1, 1, 0, 0, 0);
        ticks(1);
        chk("R9 byte fill half", pending_total, 3);
        cyc(1, 1, 0, 0, 1, 0, 0);
        chk("R9 byte cut total", pending_total, 1);
        chk("R9 byte cut len", queue_len, 1);
        chk("R9 byte cut fill", fill_active, 0);
        ticks(1);
        chk("R9 byte cut drained", pending_total, 0);
        // fill that finishes on its own
        cyc(1, 2, 0, 1, 0, 0, 0);
        ticks(1);
        chk("R10 fill still on", fill_active, 1);
        ticks(1);
        chk("R10 fill ends", fill_active, 0);
    endtask

    task automatic t_read();
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk("R11 stall on read", cpu_stall, 1);
        chk("R11 no grant yet", rd_grant, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R11 still waiting", cpu_stall, 1);
        ticks(1);
        chk("R11 grant", rd_grant, 1);
        chk("R11 stall off", cpu_stall, 0);
        step();
        chk("R11 grant one cycle", rd_grant, 0);
        cyc(0, 0, 0, 0, 0, 1, 1);
        chk("R11 same-cycle tick not used", rd_grant, 0);
        chk("R11 same-cycle stall", cpu_stall, 1);
        ticks(1);
        chk("R11 later grant", rd_grant, 1);
    endtask

    task automatic t_same();
        cyc(1, 2, 0, 0, 0, 1, 0);
        chk("R12 empty queue keeps budget", pending_total, 2);
        cyc(1, 3, 0, 0, 0, 1, 0);
        chk("R12 tick on old head", pending_total, 4);
        chk("R12 len", queue_len, 2);
        ticks(4);
        chk("R12 drained", pending_total, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=1 expected=0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_word();
        t_byte();
        t_order();
        t_drop();
        t_stall();
        t_fill();
        t_read();
        t_same();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule